// File: doc/BRIEF.md
# Stackless Jump-and-Link Program Sequencer

This block holds the program counter of a very small core that has no call stack. The counter register goes straight to the code-memory address pins and moves forward by one on every rising clock edge. When the opcode register presents the jump code, the counter loads from a target register on that edge instead. Software writes the target register beforehand through a write strobe.

Each taken jump also saves the address that follows the jump instruction into a link register, and software can read that register through an output enable. No stack exists and no return opcode exists. To return, software copies the link value into the target register and issues the ordinary jump. If calls are nested, software must save the link value itself before the next jump overwrites it.

Top module: `seq_jal_sequencer`

## Requirements
- R1: When the opcode is not the jump code, `code_addr_o` increases by exactly one on each rising clock edge. The counter register drives `code_addr_o` directly, with no added latency.
- R2: Stepping from the all-ones address gives address zero (modulo 2^ADDR_W wrap).
- R3: When `opcode_i` equals the jump code `JMP_CODE` (default 42, i.e. 6'b101010), the next edge loads `code_addr_o` with the value held in the target register.
- R4: On a jump edge the link register takes the jump's own address plus one, with modulo wrap, so a jump at all-ones links zero.
- R5: The link register changes only on a jump edge. Otherwise it keeps its value.
- R6: When `tgt_we_i` is high, the target register takes `tgt_wdata_i` on the edge, and otherwise it holds its value. If a write and a jump fall on the same edge, the jump uses the value held before the write.
- R7: `link_rdata_o` shows the link register while `link_oe_i` is high and is all zeros while it is low.
- R8: A synchronous active-high `rst` clears the counter, the link register and the target register to zero.
- R9: A return works as follows: copy the link value into the target register, then jump. Execution then resumes at the address after the calling jump.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | OPC_W | Contents of the opcode register |
| tgt_we_i | input | 1 | Write strobe for the target register |
| tgt_wdata_i | input | ADDR_W | Write data for the target register |
| link_oe_i | input | 1 | Read enable for the link register |
| link_rdata_o | output | ADDR_W | Link value when enabled, zero otherwise |
| code_addr_o | output | ADDR_W | Code-memory address (program counter) |

## Verification
The address, link and target registers all react one edge after the inputs that cause them. The read port is combinational from the link register and `link_oe_i`, so each driven cycle has one expected address and one expected read value, and both are due just after the next rising edge. The bench drives inputs on the falling edge and pushes that pair into a queue. A monitor pops the pair a quarter period after the rising edge, so the comparison never races the edge that produces it. Write-during-jump, the return idiom and the all-ones wrap each get their own driven cycles.

// File: rtl/seq_pkg.sv
package seq_pkg;

    // Source of the next program-counter value
    typedef enum logic {
        PC_STEP = 1'b0,
        PC_LOAD = 1'b1
    } pc_src_e;

    localparam int unsigned SEQ_ADDR_W_DEF = 8;
    localparam int unsigned SEQ_OPC_W_DEF  = 6;
    localparam int unsigned SEQ_JMP_DEF    = 42;

    function automatic pc_src_e pick_src(input logic is_jump);
        return is_jump ? PC_LOAD : PC_STEP;
    endfunction

endpackage

// File: rtl/seq_jump_decode.sv
module seq_jump_decode
    import seq_pkg::*;
#(
    parameter int unsigned OPC_W    = SEQ_OPC_W_DEF,
    parameter int unsigned JMP_CODE = SEQ_JMP_DEF
) (
    input  logic [OPC_W-1:0] opcode_i,
    output pc_src_e          src_o
);
    localparam logic [OPC_W-1:0] JMP_VAL = OPC_W'(JMP_CODE);

    always_comb begin
        src_o = pick_src(opcode_i == JMP_VAL);
    end
endmodule

// File: rtl/seq_pc_counter.sv
module seq_pc_counter
    import seq_pkg::*;
#(
    parameter int unsigned ADDR_W = SEQ_ADDR_W_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  pc_src_e           src_i,
    input  logic [ADDR_W-1:0] target_i,
    output logic [ADDR_W-1:0] pc_o,
    output logic [ADDR_W-1:0] pc_inc_o
);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    logic [ADDR_W-1:0] pc_q;

    always_comb begin
        pc_inc_o = pc_q + ONE;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else begin
            case (src_i)
                PC_LOAD: pc_q <= target_i;
                default: pc_q <= pc_inc_o;
            endcase
        end
    end

    assign pc_o = pc_q;
endmodule

// File: rtl/seq_hold_reg.sv
module seq_hold_reg #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         ld_i,
    input  logic [W-1:0] d_i,
    output logic [W-1:0] q_o
);
    always_ff @(posedge clk) begin
        if (rst) begin
            q_o <= '0;
        end else if (ld_i) begin
            q_o <= d_i;
        end
    end
endmodule

// File: rtl/seq_jal_sequencer.sv
module seq_jal_sequencer
    import seq_pkg::*;
#(
    parameter int unsigned ADDR_W   = SEQ_ADDR_W_DEF,
    parameter int unsigned OPC_W    = SEQ_OPC_W_DEF,
    parameter int unsigned JMP_CODE = SEQ_JMP_DEF
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [OPC_W-1:0]  opcode_i,
    input  logic              tgt_we_i,
    input  logic [ADDR_W-1:0] tgt_wdata_i,
    input  logic              link_oe_i,
    output logic [ADDR_W-1:0] link_rdata_o,
    output logic [ADDR_W-1:0] code_addr_o
);
    pc_src_e           src;
    logic [ADDR_W-1:0] target_q;
    logic [ADDR_W-1:0] link_q;
    logic [ADDR_W-1:0] pc_inc;
    logic              take_jump;

    seq_jump_decode #(
        .OPC_W    (OPC_W),
        .JMP_CODE (JMP_CODE)
    ) u_dec (
        .opcode_i (opcode_i),
        .src_o    (src)
    );

    assign take_jump = (src == PC_LOAD);

    seq_pc_counter #(
        .ADDR_W (ADDR_W)
    ) u_pc (
        .clk      (clk),
        .rst      (rst),
        .src_i    (src),
        .target_i (target_q),
        .pc_o     (code_addr_o),
        .pc_inc_o (pc_inc)
    );

    // Software-written jump destination
    seq_hold_reg #(
        .W (ADDR_W)
    ) u_target (
        .clk  (clk),
        .rst  (rst),
        .ld_i (tgt_we_i),
        .d_i  (tgt_wdata_i),
        .q_o  (target_q)
    );

    // Address after the jump, captured only on a taken jump
    seq_hold_reg #(
        .W (ADDR_W)
    ) u_link (
        .clk  (clk),
        .rst  (rst),
        .ld_i (take_jump),
        .d_i  (pc_inc),
        .q_o  (link_q)
    );

    always_comb begin
        link_rdata_o = link_oe_i ? link_q : '0;
    end
endmodule

// File: rtl/seq_jal_sequencer_chk.sv
module seq_jal_sequencer_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned OPC_W    = 6,
    parameter int unsigned JMP_CODE = 42
) (
    input logic              clk,
    input logic              rst,
    input logic [OPC_W-1:0]  opcode_i,
    input logic              tgt_we_i,
    input logic [ADDR_W-1:0] code_addr_o,
    input logic [ADDR_W-1:0] target_q,
    input logic [ADDR_W-1:0] link_q
);
    localparam logic [OPC_W-1:0]  JV  = OPC_W'(JMP_CODE);
    localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

    p_step_r1: assert property (@(posedge clk) disable iff (rst)
        (opcode_i != JV) |=> (code_addr_o == $past(code_addr_o) + ONE));

    p_jump_r3: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == JV) |=> (code_addr_o == $past(target_q)));

    p_link_r4: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == JV) |=> (link_q == $past(code_addr_o) + ONE));

    p_link_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (opcode_i != JV) |=> $stable(link_q));

    p_target_hold_r6: assert property (@(posedge clk) disable iff (rst)
        !tgt_we_i |=> $stable(target_q));

    p_reset_r8: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (code_addr_o == '0 && link_q == '0 && target_q == '0));
endmodule

bind seq_jal_sequencer seq_jal_sequencer_chk #(
    .ADDR_W   (ADDR_W),
    .OPC_W    (OPC_W),
    .JMP_CODE (JMP_CODE)
) u_chk (
    .clk         (clk),
    .rst         (rst),
    .opcode_i    (opcode_i),
    .tgt_we_i    (tgt_we_i),
    .code_addr_o (code_addr_o),
    .target_q    (target_q),
    .link_q      (link_q)
);

// File: tb/tb_seq_jal_sequencer.sv
module tb_seq_jal_sequencer;
    localparam int unsigned AW  = 8;
    localparam int unsigned OW  = 6;
    localparam int unsigned JC  = 42;
    localparam logic [OW-1:0] JMP = OW'(JC);
    localparam logic [OW-1:0] NOP = '0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [AW-1:0] rdata;
        string         tag;
    } exp_t;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic [OW-1:0] opcode = '0;
    logic          we = 1'b0;
    logic [AW-1:0] wdata = '0;
    logic          oe = 1'b0;
    logic [AW-1:0] rdata;
    logic [AW-1:0] addr;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    exp_t q[$];

    // model state
    logic [AW-1:0] m_pc = '0, m_link = '0, m_tgt = '0;

    always #10 clk = ~clk;

    seq_jal_sequencer #(.ADDR_W(AW), .OPC_W(OW), .JMP_CODE(JC)) dut (
        .clk          (clk),
        .rst          (rst),
        .opcode_i     (opcode),
        .tgt_we_i     (we),
        .tgt_wdata_i  (wdata),
        .link_oe_i    (oe),
        .link_rdata_o (rdata),
        .code_addr_o  (addr)
    );

    // Driver: one clock cycle of stimulus, expectation pushed for the next edge
    task automatic step(input logic r, input logic [OW-1:0] op, input logic w,
                        input logic [AW-1:0] wd, input logic o, input string tag);
        exp_t e;
        @(negedge clk);
        rst = r; opcode = op; we = w; wdata = wd; oe = o;
        if (r) begin
            m_pc = '0; m_link = '0; m_tgt = '0;
        end else begin
            if (op == JMP) begin
                m_link = m_pc + 1'b1;
                m_pc   = m_tgt;
            end else begin
                m_pc = m_pc + 1'b1;
            end
            if (w) m_tgt = wd;
        end
        e.addr  = m_pc;
        e.rdata = o ? m_link : '0;
        e.tag   = tag;
        q.push_back(e);
    endtask

    // Monitor: compares a quarter period after each rising edge
    always @(posedge clk) begin
        #5;
        if (q.size() > 0) begin
            exp_t e;
            e = q.pop_front();
            checks++;
            if (addr !== e.addr) begin
                errors++;
                $display("FAIL %s code_addr actual=%0h expected=%0h", e.tag, addr, e.addr);
            end
            checks++;
            if (rdata !== e.rdata) begin
                errors++;
                $display("FAIL %s link_rdata actual=%0h expected=%0h", e.tag, rdata, e.rdata);
            end
        end
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [AW-1:0] saved;
        // R8: reset state
        step(1, NOP, 0, '0, 1, "R8");
        step(1, NOP, 0, '0, 1, "R8");
        // R1 stepping, R7 read disabled gives zero
        for (int i = 0; i < 5; i++) step(0, NOP, 0, '0, 0, "R1");
        // R6 write target, R7 read enabled
        step(0, NOP, 1, 8'h40, 1, "R6");
        step(0, NOP, 0, 8'h11, 1, "R7");
        // R3 jump, R4 link
        step(0, JMP, 0, '0, 1, "R3");
        step(0, NOP, 0, '0, 1, "R4");
        // R5 link holds while stepping and writing target
        for (int i = 0; i < 3; i++) step(0, NOP, i == 1, 8'h77, 1, "R5");
        // R6 write and jump on same edge: old target used
        step(0, NOP, 1, 8'h20, 0, "R6");
        step(0, JMP, 1, 8'h90, 1, "R6");
        step(0, JMP, 0, '0, 1, "R6");
        step(0, NOP, 0, '0, 1, "R6");
        // R9 return idiom: call 0x80, copy link to target, jump back
        step(0, NOP, 1, 8'h80, 0, "R9");
        step(0, JMP, 0, '0, 1, "R9");
        saved = m_link;
        step(0, NOP, 1, saved, 1, "R9");
        step(0, JMP, 0, '0, 1, "R9");
        step(0, NOP, 0, '0, 1, "R9");
        // R2 wrap: jump to FD then step past all-ones
        step(0, NOP, 1, 8'hFD, 0, "R2");
        step(0, JMP, 0, '0, 0, "R2");
        for (int i = 0; i < 4; i++) step(0, NOP, 0, '0, 0, "R2");
        // R4 jump located at all-ones links zero
        step(0, NOP, 1, 8'hFE, 0, "R4");
        step(0, JMP, 0, '0, 0, "R4");
        step(0, NOP, 1, 8'h10, 0, "R4");
        step(0, JMP, 0, '0, 1, "R4");
        step(0, NOP, 0, '0, 1, "R4");
        // R1 longer run with alternating read enable
        for (int i = 0; i < 20; i++) step(0, NOP, 0, '0, i[0], "R1");
        // R8 reset mid-run
        step(1, NOP, 0, '0, 1, "R8");
        step(0, NOP, 0, '0, 1, "R8");
        step(0, JMP, 0, '0, 1, "R8");
        step(0, NOP, 0, '0, 1, "R8");
        @(negedge clk);
        opcode = NOP; oe = 1'b0; we = 1'b0;
        @(negedge clk);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule